// File: doc/BRIEF.md
# Background Tile Pixel Shifter

This block produces the 4-bit background colour index for each pixel of a scanline. It holds two tiles' worth of one pattern row in a pair of 16-bit bit-plane registers, one for the low plane and one for the high plane. A matching pair of 8-bit registers carries the palette-select bits. On every visible cycle all four registers move one place towards the most significant bit. A reload strobe, raised once per 8 pixels, writes the next tile's row into the lower half of each pattern register.

Fine horizontal scrolling selects a fixed tap near the top of each register, picked by the 3-bit fine X value. The fetch address is not moved. The attribute registers are fed one bit per shift from a pair of 1-bit latches. These latches are refilled at each reload, which keeps the palette bits in step with the pattern bits. The colour index is combinational from the register state and the fine X and masking inputs. It can be forced to zero when the background is disabled, or in the leftmost 8 columns when clipping is on.

Top module: `bg_pixel_shifter`

## Requirements
- R1: After reset, all pattern registers, attribute registers and attribute latches are zero, so `pix_idx` is 0 with the background shown.
- R2: On a clock edge with `shift_en` high, each pattern register and each attribute register moves left by one bit. With `shift_en` and `reload` both low, all register state holds.
- R3: On a clock edge with `reload` high, bits 7:0 of the low-plane register take `pat_lo` and bits 7:0 of the high-plane register take `pat_hi`. Bits 15:8 keep their value, or their shifted value when `shift_en` is also high.
- R4: With no masking active, `pix_idx[0]` is bit (15 − `fine_x`) of the low-plane register and `pix_idx[1]` is the same bit of the high-plane register.
- R5: On reload, the two attribute latches take `attr_bits` (bit 0 for the low palette plane, bit 1 for the high plane). Each shift moves the latch's current value into bit 0 of its attribute register. `pix_idx[2]` and `pix_idx[3]` are bit (7 − `fine_x`) of the low and high attribute registers.
- R6: When `bg_enable` is low, `pix_idx` is 0 whatever the register contents.
- R7: When `left_clip_n` is low and `left_col` is high, `pix_idx` is 0. When `left_clip_n` is high, `left_col` has no effect.
- R8: When `reload` and `shift_en` are high together, the registers shift first and the new bytes then replace bits 7:0. The attribute registers shift in the old latch value, not the new `attr_bits`.
- R9: A change of `fine_x` changes `pix_idx` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_en | input | 1 | Visible-cycle enable: shift all registers one place |
| reload | input | 1 | Load the next tile's row and attribute bits |
| pat_lo | input | 8 | Next tile's low bit-plane row |
| pat_hi | input | 8 | Next tile's high bit-plane row |
| attr_bits | input | 2 | Next tile's palette-select bits |
| fine_x | input | 3 | Fine horizontal scroll, selects the tap |
| bg_enable | input | 1 | Background enable mask bit |
| left_clip_n | input | 1 | Show background in the leftmost 8 columns when high |
| left_col | input | 1 | Current pixel lies in the leftmost 8 columns |
| pix_idx | output | 4 | Background colour index {attr hi, attr lo, plane hi, plane lo} |

## Verification
A register update driven by `shift_en`, `reload` or `attr_bits` shows at `pix_idx` one clock edge after the cycle that presents it. A change of `fine_x` or of a mask input shows in the same cycle. The driver therefore applies every input at a falling edge. After the next rising edge it updates its reference registers and queues the expected index together with the requirement under test. The monitor takes each queued item 1 ns after that rising edge, while the inputs are still held, so each comparison covers exactly one edge of register latency and no more.

// File: rtl/bgpx_pkg.sv
package bgpx_pkg;
    localparam int TILE_W = 8;               // pixels per tile row
    localparam int PLANES = 2;               // pattern / palette planes
    localparam int PIX_W  = 2 * PLANES;      // colour index width
endpackage

// File: rtl/bgpx_pat_plane.sv
module bgpx_pat_plane #(
    parameter int TILE_W = bgpx_pkg::TILE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic                  reload,
    input  logic [TILE_W-1:0]     load_byte,
    output logic [2*TILE_W-1:0]   sr_q
);
    localparam int SR_W = 2 * TILE_W;

    typedef struct packed {
        logic [SR_W-1:0] sr;
    } plane_st_t;

    plane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {st_q.sr[SR_W-2:0], 1'b0};
        end
        if (reload) begin
            st_d.sr[TILE_W-1:0] = load_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_q = st_q.sr;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !reload) |=> $stable(sr_q));

    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !reload) |=> (sr_q == {$past(sr_q[SR_W-2:0]), 1'b0}));

    p_load_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (sr_q[TILE_W-1:0] == $past(load_byte)));

    p_upper_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && shift_en) |=> (sr_q[SR_W-1:TILE_W] == $past(sr_q[SR_W-2:TILE_W-1])));
endmodule

// File: rtl/bgpx_attr_plane.sv
module bgpx_attr_plane #(
    parameter int TILE_W = bgpx_pkg::TILE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                reload,
    input  logic                attr_in,
    output logic [TILE_W-1:0]   sr_q
);
    typedef struct packed {
        logic              feed;
        logic [TILE_W-1:0] sr;
    } attr_st_t;

    attr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {st_q.sr[TILE_W-2:0], st_q.feed};
        end
        if (reload) begin
            st_d.feed = attr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_q = st_q.sr;

    p_attr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));

    p_attr_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr_q[TILE_W-1:1] == $past(sr_q[TILE_W-2:0])));

    p_feed_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && reload) ##1 shift_en |=> (sr_q[0] == $past(attr_in, 2)));
endmodule

// File: rtl/bgpx_pixel_select.sv
module bgpx_pixel_select #(
    parameter int TILE_W = bgpx_pkg::TILE_W,
    parameter int PLANES = bgpx_pkg::PLANES
) (
    input  logic [PLANES-1:0][2*TILE_W-1:0] pat_sr,
    input  logic [PLANES-1:0][TILE_W-1:0]   attr_sr,
    input  logic [$clog2(TILE_W)-1:0]       fine_x,
    input  logic                            bg_enable,
    input  logic                            left_clip_n,
    input  logic                            left_col,
    output logic [2*PLANES-1:0]             pix_idx
);
    localparam int FX_W = $clog2(TILE_W);

    logic [FX_W:0]       pat_tap;
    logic [FX_W-1:0]     attr_tap;
    logic                visible;
    logic [2*PLANES-1:0] raw_idx;

    // Tile width is a power of two: (2*TILE_W-1 - fx) = {1, ~fx}, (TILE_W-1 - fx) = ~fx.
    assign pat_tap  = {1'b1, ~fine_x};
    assign attr_tap = ~fine_x;
    assign visible  = bg_enable && (left_clip_n || !left_col);

    for (genvar g = 0; g < PLANES; g++) begin : g_tap
        assign raw_idx[g]          = pat_sr[g][pat_tap];
        assign raw_idx[PLANES + g] = attr_sr[g][attr_tap];
    end

    assign pix_idx = visible ? raw_idx : '0;
endmodule

// File: rtl/bg_pixel_shifter.sv
module bg_pixel_shifter #(
    parameter int TILE_W = bgpx_pkg::TILE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic                        reload,
    input  logic [TILE_W-1:0]           pat_lo,
    input  logic [TILE_W-1:0]           pat_hi,
    input  logic [1:0]                  attr_bits,
    input  logic [$clog2(TILE_W)-1:0]   fine_x,
    input  logic                        bg_enable,
    input  logic                        left_clip_n,
    input  logic                        left_col,
    output logic [3:0]                  pix_idx
);
    localparam int PLANES = bgpx_pkg::PLANES;
    localparam int SR_W   = 2 * TILE_W;

    logic [PLANES-1:0][TILE_W-1:0] pat_in;
    logic [PLANES-1:0][SR_W-1:0]   pat_sr;
    logic [PLANES-1:0][TILE_W-1:0] attr_sr;

    assign pat_in = {pat_hi, pat_lo};

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        bgpx_pat_plane #(.TILE_W(TILE_W)) i_pat (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_en  (shift_en),
            .reload    (reload),
            .load_byte (pat_in[p]),
            .sr_q      (pat_sr[p])
        );
        bgpx_attr_plane #(.TILE_W(TILE_W)) i_attr (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .reload   (reload),
            .attr_in  (attr_bits[p]),
            .sr_q     (attr_sr[p])
        );
    end

    bgpx_pixel_select #(.TILE_W(TILE_W), .PLANES(PLANES)) i_sel (
        .pat_sr      (pat_sr),
        .attr_sr     (attr_sr),
        .fine_x      (fine_x),
        .bg_enable   (bg_enable),
        .left_clip_n (left_clip_n),
        .left_col    (left_col),
        .pix_idx     (pix_idx)
    );

    p_bg_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bg_enable |-> (pix_idx == 4'd0));

    p_left_clip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!left_clip_n && left_col) |-> (pix_idx == 4'd0));

    p_tap_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bg_enable && left_clip_n && fine_x == '0) |-> (pix_idx[0] == pat_sr[0][SR_W-1]));
endmodule

// File: tb/test_bg_pixel_shifter.sv
`timescale 1ns/1ps
module test_bg_pixel_shifter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_en = 1'b0, reload = 1'b0;
    logic [7:0] pat_lo = '0, pat_hi = '0;
    logic [1:0] attr_bits = '0;
    logic [2:0] fine_x = '0;
    logic       bg_enable = 1'b1, left_clip_n = 1'b1, left_col = 1'b0;
    logic [3:0] pix_idx;

    bg_pixel_shifter i_bg_pixel_shifter (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .reload(reload),
        .pat_lo(pat_lo), .pat_hi(pat_hi), .attr_bits(attr_bits),
        .fine_x(fine_x), .bg_enable(bg_enable), .left_clip_n(left_clip_n),
        .left_col(left_col), .pix_idx(pix_idx)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;

    typedef struct { logic [3:0] pix; string req; } exp_t;
    exp_t exp_q[$];

    // reference registers built from the requirements
    logic [15:0] m_lo = '0, m_hi = '0;
    logic [7:0]  m_al = '0, m_ah = '0;
    logic [1:0]  m_feed = '0;
    logic [2:0]  b_fx = '0;
    logic        b_bg = 1'b1, b_lc = 1'b1, b_col = 1'b0;

    function automatic logic [3:0] model_pix();
        if (!b_bg || (!b_lc && b_col)) return 4'd0;
        return {m_ah[7-b_fx], m_al[7-b_fx], m_hi[15-b_fx], m_lo[15-b_fx]};
    endfunction

    task automatic step(input logic sh, input logic rl, input logic [7:0] lo,
                        input logic [7:0] hi, input logic [1:0] at, input string tag);
        exp_t e;
        @(negedge clk);
        shift_en = sh; reload = rl; pat_lo = lo; pat_hi = hi; attr_bits = at;
        fine_x = b_fx; bg_enable = b_bg; left_clip_n = b_lc; left_col = b_col;
        @(posedge clk);
        if (sh) begin
            m_lo = m_lo << 1; m_hi = m_hi << 1;
            m_al = {m_al[6:0], m_feed[0]}; m_ah = {m_ah[6:0], m_feed[1]};
        end
        if (rl) begin
            m_lo[7:0] = lo; m_hi[7:0] = hi; m_feed = at;
        end
        e.pix = model_pix(); e.req = tag;
        exp_q.push_back(e);
    endtask

    // monitor: one edge of latency, sampled while inputs are held
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (pix_idx !== e.pix) begin
                errors++;
                $display("FAIL %s pix_idx actual %h expected %h", e.req, pix_idx, e.pix);
            end
        end
    end

    // same-cycle tap change: no edge, sampled after a settle delay
    task automatic fx_now(input logic [2:0] fx, input string tag);
        logic [3:0] exp_v;
        @(negedge clk);
        b_fx = fx; fine_x = fx; shift_en = 1'b0; reload = 1'b0;
        #0.5;
        exp_v = model_pix();
        checks++;
        if (pix_idx !== exp_v) begin
            errors++;
            $display("FAIL %s pix_idx actual %h expected %h", tag, pix_idx, exp_v);
        end
        @(posedge clk);
    endtask

    initial begin : watchdog
        #500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        checks++;
        if (pix_idx !== 4'd0) begin
            errors++;
            $display("FAIL R1 reset pix_idx actual %h expected 0", pix_idx);
        end

        // R3: load tile A without shifting, then R2 shifts bring it to the tap
        step(1'b0, 1'b1, 8'hA5, 8'h3C, 2'b10, "R3");
        step(1'b0, 1'b0, 8'h00, 8'h00, 2'b00, "R2 hold");
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, "R2");
        // R8: eighth shift coincides with reload of tile B
        step(1'b1, 1'b1, 8'h96, 8'hF0, 2'b01, "R8");
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, "R5 R4");
        // R9: tap sweep on held state
        for (int f = 0; f < 8; f++) fx_now(3'(f), "R9");
        b_fx = 3'd3;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, "R4");
        // R6: background disabled
        b_bg = 1'b0;
        step(1'b1, 1'b1, 8'hFF, 8'hFF, 2'b11, "R6");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, "R6");
        b_bg = 1'b1;
        // R7: left clipping
        b_lc = 1'b0; b_col = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, "R7 clip");
        b_lc = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, "R7 shown");
        b_lc = 1'b0; b_col = 1'b0;
        for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, "R7 right");
        b_lc = 1'b1;
        // long run: reload every 8 shifts, varied tiles and taps
        for (int t = 0; t < 24; t++) begin
            b_fx = 3'(t * 5);
            for (int c = 0; c < 8; c++) begin
                step(1'b1, c == 7, 8'(t * 37 + 11), 8'(t * 91 + 5), 2'(t), "R5 R2");
            end
        end
        repeat (2) @(posedge clk);
        #2;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule